// File: doc/BRIEF.md
# LIN Header Break and Baud Detector

This block watches the receive line of a single-wire serial bus that uses LIN framing and recovers the bus timing from the header of each frame. It detects the long dominant-low break that opens a frame, waits for the line to return high, and times the synchronization byte. The sync byte carries a fixed pattern of alternating bits. The block counts system clock cycles from the first falling edge of that byte to its fifth falling edge. That span covers eight bit periods, so the span and the span shifted right by three are the values a UART needs to set its baud divisor, either fractional or integer.

Break detection stays armed whenever the block is enabled. This includes the part of a frame where the downstream UART is receiving data bytes and the middle of a sync measurement. A break that arrives during a measurement abandons it and starts a new header. A line held low far beyond a break raises a sticky bus-fault flag. A header that stops before the fifth sync edge raises a sticky sync-error flag once a timeout expires. Both flags stay set until a clear pulse. The protected identifier, the data bytes and the UART itself are outside this block.

Top module: `lin_hdr_baud_detect`

## Requirements
- R1: After reset, brk_det, sync_done, sync_err and bus_fault are 0 and sync_count and bit_period are 0.
- R2: While enabled, a low run on the synchronized line that lasts brk_thresh cycles produces exactly one single-cycle brk_det pulse. A shorter low run, such as a 0x00 data byte of nine bit periods low, produces none.
- R3: A break that occurs during a sync measurement aborts that measurement, with no sync_done. The next header is then measured correctly.
- R4: After a break and its rising delimiter, sync_count equals the number of clock cycles between the first and fifth falling edges of the line. For the byte 0x55, sent LSB first with a start bit, this is 8 times the bit period in cycles.
- R5: bit_period equals sync_count shifted right by 3. Both are updated together with a sync_done pulse that lasts exactly one cycle, and both hold their values until the next completed measurement.
- R6: If the fifth falling edge has not arrived SYNC_TIMEOUT cycles after the break ends, the block returns to idle without sync_done and sets sync_err. sync_err stays set until err_clear.
- R7: A low run of fault_limit cycles that begins with a break sets bus_fault. bus_fault stays set after the line returns high and after later headers, until err_clear.
- R8: While enable is low, no brk_det or sync_done is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Arms detection; low forces the idle state |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| brk_thresh | input | CNT_W | Low-run length, in clocks, accepted as a break |
| fault_limit | input | CNT_W | Low-run length, in clocks, flagged as a bus fault |
| err_clear | input | 1 | Clears sync_err and bus_fault |
| brk_det | output | 1 | One-cycle pulse when a break is recognized |
| sync_done | output | 1 | One-cycle strobe when a new measurement is valid |
| sync_count | output | CNT_W | Clocks between first and fifth sync falling edges |
| bit_period | output | CNT_W-3 | sync_count divided by 8 |
| sync_err | output | 1 | Sticky: sync field timed out |
| bus_fault | output | 1 | Sticky: line held low past fault_limit |

## Verification
The assertions assume that err_clear is a short pulse and that fault_limit is larger than brk_thresh, so that a fault is always preceded by a break. The bench meets this by programming brk_thresh to 11 bit periods and fault_limit to 1000 cycles. The bench changes rx_in only on falling clock edges and holds each bit for a whole number of cycles. With that timing, the expected span is exactly eight bit periods, because the synchronizer delays every edge by the same amount. Bit periods are kept small enough that a full sync byte ends well inside the timeout, so only the deliberately truncated header reaches it.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE         = 3'd0,
      ST_BREAK        = 3'd1,
      ST_WAIT_DELIM   = 3'd2,
      ST_SYNC_MEASURE = 3'd3,
      ST_DONE         = 3'd4,
      ST_FAULT        = 3'd5
   } hdr_state_e;
endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_in,
   output logic rx_s,
   output logic fall,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              rx_prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lin_rx_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= rx_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_prev <= 1'b1;
      else        rx_prev <= chain[STAGES-1];
   end

   assign rx_s = chain[STAGES-1];
   assign fall = rx_prev & ~rx_s;
   assign rise = ~rx_prev & rx_s;
endmodule

// File: rtl/lin_low_timer.sv
module lin_low_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_s,
   output logic [CNT_W-1:0] low_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                low_cnt <= '0;
      else if (rx_s)             low_cnt <= '0;
      else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
   end
endmodule

// File: rtl/lin_sync_meter.sv
module lin_sync_meter #(
   parameter int CNT_W        = 16,
   parameter int SYNC_EDGES   = 5,
   parameter int SYNC_TIMEOUT = 4000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             begin_meas,
   input  logic             measuring,
   input  logic             waiting,
   input  logic             fall,
   output logic [CNT_W-1:0] span,
   output logic             final_edge,
   output logic             tmo_hit
);
   localparam int TMO_W = $clog2(SYNC_TIMEOUT + 1);
   localparam int EDG_W = $clog2(SYNC_EDGES + 1);
   localparam logic [CNT_W-1:0] SPAN_MAX = '1;
   localparam logic [TMO_W-1:0] TMO_END  = TMO_W'(SYNC_TIMEOUT);
   localparam logic [EDG_W-1:0] EDG_LAST = EDG_W'(SYNC_EDGES - 1);

   logic [TMO_W-1:0] tmo;
   logic [EDG_W-1:0] edges;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         span  <= '0;
         edges <= '0;
      end else if (begin_meas) begin
         span  <= CNT_W'(1);
         edges <= EDG_W'(1);
      end else if (measuring) begin
         if (span != SPAN_MAX) span <= span + 1'b1;
         if (fall)             edges <= edges + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        tmo <= '0;
      else if (arm)                      tmo <= '0;
      else if (waiting && tmo != TMO_END) tmo <= tmo + 1'b1;
   end

   assign final_edge = measuring && fall && (edges == EDG_LAST);
   assign tmo_hit    = waiting && (tmo == TMO_END);
endmodule

// File: rtl/lin_hdr_baud_detect.sv
module lin_hdr_baud_detect #(
   parameter int CNT_W        = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int SYNC_EDGES   = 5,
   parameter int SYNC_TIMEOUT = 4000,
   localparam int PERIODS     = 2 * (SYNC_EDGES - 1),
   localparam int SHIFT       = $clog2(PERIODS),
   localparam int BP_W        = CNT_W - SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             rx_in,
   input  logic [CNT_W-1:0] brk_thresh,
   input  logic [CNT_W-1:0] fault_limit,
   input  logic             err_clear,
   output logic             brk_det,
   output logic             sync_done,
   output logic [CNT_W-1:0] sync_count,
   output logic [BP_W-1:0]  bit_period,
   output logic             sync_err,
   output logic             bus_fault
);
   import lin_hdr_pkg::*;

   generate
      if (SYNC_EDGES < 2) begin : g_bad_edges
         $error("lin_hdr_baud_detect: SYNC_EDGES must be at least 2");
      end
      if ((1 << SHIFT) != PERIODS) begin : g_bad_periods
         $error("lin_hdr_baud_detect: bit periods spanned must be a power of two");
      end
      if (CNT_W <= SHIFT + 4) begin : g_bad_width
         $error("lin_hdr_baud_detect: CNT_W too small");
      end
      if (SYNC_TIMEOUT >= (1 << CNT_W)) begin : g_bad_tmo
         $error("lin_hdr_baud_detect: SYNC_TIMEOUT must fit in CNT_W");
      end
   endgenerate

   logic             rx_s, fall, rise;
   logic [CNT_W-1:0] low_cnt;
   logic [CNT_W-1:0] span;
   logic             final_edge, tmo_hit;
   logic             brk_hit;
   logic             arm, begin_meas, measuring, waiting;
   logic             tmo_exit, fault_entry;
   hdr_state_e       state, nxt;

   lin_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .rx_in (rx_in),
      .rx_s  (rx_s),
      .fall  (fall),
      .rise  (rise)
   );

   lin_low_timer #(.CNT_W(CNT_W)) u_low (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_s    (rx_s),
      .low_cnt (low_cnt)
   );

   lin_sync_meter #(
      .CNT_W        (CNT_W),
      .SYNC_EDGES   (SYNC_EDGES),
      .SYNC_TIMEOUT (SYNC_TIMEOUT)
   ) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .begin_meas (begin_meas),
      .measuring  (measuring),
      .waiting    (waiting),
      .fall       (fall),
      .span       (span),
      .final_edge (final_edge),
      .tmo_hit    (tmo_hit)
   );

   assign brk_hit   = !rx_s && (low_cnt >= brk_thresh);
   assign measuring = (state == ST_SYNC_MEASURE);
   assign waiting   = (state == ST_WAIT_DELIM) || measuring;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:         if (brk_hit) nxt = ST_BREAK;
         ST_BREAK: begin
            if (rise)                           nxt = ST_WAIT_DELIM;
            else if (low_cnt >= fault_limit)    nxt = ST_FAULT;
         end
         ST_WAIT_DELIM: begin
            if (tmo_hit)   nxt = ST_IDLE;
            else if (fall) nxt = ST_SYNC_MEASURE;
         end
         ST_SYNC_MEASURE: begin
            if (brk_hit)         nxt = ST_BREAK;
            else if (final_edge) nxt = ST_DONE;
            else if (tmo_hit)    nxt = ST_IDLE;
         end
         ST_DONE:         nxt = brk_hit ? ST_BREAK : ST_IDLE;
         ST_FAULT:        if (rise) nxt = ST_IDLE;
         default:         nxt = ST_IDLE;
      endcase
      if (!enable) nxt = ST_IDLE;
   end

   assign arm         = (state == ST_BREAK) && (nxt == ST_WAIT_DELIM);
   assign begin_meas  = (state == ST_WAIT_DELIM) && (nxt == ST_SYNC_MEASURE);
   assign tmo_exit    = enable && waiting && tmo_hit && (nxt == ST_IDLE);
   assign fault_entry = (state == ST_BREAK) && (nxt == ST_FAULT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_det    <= 1'b0;
         sync_count <= '0;
         bit_period <= '0;
      end else begin
         brk_det <= (nxt == ST_BREAK) && (state != ST_BREAK);
         if (measuring && nxt == ST_DONE) begin
            sync_count <= span;
            bit_period <= span[CNT_W-1:SHIFT];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_err  <= 1'b0;
         bus_fault <= 1'b0;
      end else begin
         if (tmo_exit)       sync_err <= 1'b1;
         else if (err_clear) sync_err <= 1'b0;
         if (fault_entry)    bus_fault <= 1'b1;
         else if (err_clear) bus_fault <= 1'b0;
      end
   end

   assign sync_done = (state == ST_DONE);
endmodule

// File: rtl/lin_hdr_baud_detect_chk.sv
module lin_hdr_baud_detect_chk #(
   parameter int CNT_W = 16,
   parameter int SHIFT = 3,
   parameter int BP_W  = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             err_clear,
   input logic             brk_det,
   input logic             sync_done,
   input logic [CNT_W-1:0] sync_count,
   input logic [BP_W-1:0]  bit_period,
   input logic             sync_err,
   input logic             bus_fault
);
   a_r2_brk_single: assert property (@(posedge clk) disable iff (!rst_n)
      brk_det |=> !brk_det);

   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      sync_done |=> !sync_done);

   a_r5_period_matches: assert property (@(posedge clk) disable iff (!rst_n)
      sync_done |-> (bit_period == sync_count[CNT_W-1:SHIFT]));

   a_r5_count_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sync_count) |-> sync_done);

   a_r3_no_done_with_brk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sync_done && brk_det));

   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_err && !err_clear) |=> sync_err);

   a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_fault && !err_clear) |=> bus_fault);

   a_r7_fault_after_brk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_fault) |-> !brk_det);

   a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!brk_det && !sync_done));
endmodule

bind lin_hdr_baud_detect lin_hdr_baud_detect_chk #(
   .CNT_W (CNT_W),
   .SHIFT (SHIFT),
   .BP_W  (BP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .err_clear  (err_clear),
   .brk_det    (brk_det),
   .sync_done  (sync_done),
   .sync_count (sync_count),
   .bit_period (bit_period),
   .sync_err   (sync_err),
   .bus_fault  (bus_fault)
);

// File: tb/lin_hdr_baud_detect_test.sv
module lin_hdr_baud_detect_test;
   localparam int CW   = 16;
   localparam int TMO  = 1000;
   localparam int BPW  = CW - 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          rx_in = 1'b1;
   logic [CW-1:0] brk_thresh = CW'(220);
   logic [CW-1:0] fault_limit = CW'(1000);
   logic          err_clear = 1'b0;
   logic          brk_det, sync_done, sync_err, bus_fault;
   logic [CW-1:0] sync_count;
   logic [BPW-1:0] bit_period;

   int checks = 0;
   int errors = 0;
   int brk_seen = 0;
   int exp_q[$];

   always #5 clk = ~clk;

   lin_hdr_baud_detect #(.CNT_W(CW), .SYNC_TIMEOUT(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .rx_in(rx_in),
      .brk_thresh(brk_thresh), .fault_limit(fault_limit), .err_clear(err_clear),
      .brk_det(brk_det), .sync_done(sync_done), .sync_count(sync_count),
      .bit_period(bit_period), .sync_err(sync_err), .bus_fault(bus_fault)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: pops expected spans on each sync_done and counts break pulses
   always @(negedge clk) begin
      if (rst_n && brk_det) brk_seen++;
      if (rst_n && sync_done) begin
         if (exp_q.size() == 0) begin
            check(0, "R3/R8 unexpected sync_done", int'(sync_count), -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            check(int'(sync_count) == e, "R4 sync_count", int'(sync_count), e);
            check(int'(bit_period) == e / 8, "R5 bit_period", int'(bit_period), e / 8);
         end
      end
   end

   task automatic hold(input logic v, input int n);
      rx_in = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input int p);
      hold(1'b0, p);
      for (int i = 0; i < 8; i++) hold(b[i], p);
      hold(1'b1, p);
   endtask

   task automatic send_header(input int p, input bit expect_done);
      brk_thresh = CW'(11 * p);
      hold(1'b0, 14 * p);
      hold(1'b1, 2 * p);
      if (expect_done) exp_q.push_back(8 * p);
      send_byte(8'h55, p);
      hold(1'b1, 10);
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      check(!brk_det && !sync_done, "R1 strobes", int'(brk_det | sync_done), 0);
      check(!sync_err && !bus_fault, "R1 flags", int'(sync_err | bus_fault), 0);
      check(sync_count == 0 && bit_period == 0, "R1 count", int'(sync_count), 0);
      enable = 1'b1;
      hold(1'b1, 20);

      // R4/R5 headers at several bit periods
      b0 = brk_seen;
      send_header(20, 1);
      send_header(37, 1);
      send_header(13, 1);
      check(brk_seen - b0 == 3, "R2 one pulse per break", brk_seen - b0, 3);
      check(exp_q.size() == 0, "R5 all headers measured", exp_q.size(), 0);

      // R2 a 0x00 data byte is too short to be a break
      b0 = brk_seen;
      send_byte(8'h00, 13);
      send_byte(8'h00, 13);
      hold(1'b1, 20);
      check(brk_seen == b0, "R2 data byte no break", brk_seen - b0, 0);
      check(sync_count == 104, "R5 count held", int'(sync_count), 104);

      // R3 break in the middle of the sync field
      b0 = brk_seen;
      brk_thresh = CW'(220);
      hold(1'b0, 280);
      hold(1'b1, 40);
      hold(1'b0, 20);
      hold(1'b1, 20);
      hold(1'b0, 300);
      hold(1'b1, 40);
      exp_q.push_back(160);
      send_byte(8'h55, 20);
      hold(1'b1, 10);
      check(brk_seen - b0 == 2, "R3 abort break seen", brk_seen - b0, 2);
      check(exp_q.size() == 0, "R3 resumed measurement", exp_q.size(), 0);

      // R6 truncated header times out
      hold(1'b0, 280);
      hold(1'b1, TMO + 100);
      check(sync_err == 1'b1, "R6 sync_err set", int'(sync_err), 1);
      err_clear = 1'b1;
      @(negedge clk);
      err_clear = 1'b0;
      @(negedge clk);
      check(sync_err == 1'b0, "R6 sync_err cleared", int'(sync_err), 0);

      // R7 stuck-low line
      b0 = brk_seen;
      hold(1'b0, 1300);
      hold(1'b1, 50);
      check(bus_fault == 1'b1, "R7 bus_fault set", int'(bus_fault), 1);
      check(brk_seen - b0 == 1, "R7 break before fault", brk_seen - b0, 1);
      send_header(20, 1);
      check(bus_fault == 1'b1, "R7 bus_fault sticky", int'(bus_fault), 1);
      err_clear = 1'b1;
      @(negedge clk);
      err_clear = 1'b0;
      @(negedge clk);
      check(bus_fault == 1'b0, "R7 bus_fault cleared", int'(bus_fault), 0);

      // R8 disabled block stays silent
      enable = 1'b0;
      b0 = brk_seen;
      send_header(20, 0);
      check(brk_seen == b0, "R8 no break when disabled", brk_seen - b0, 0);
      enable = 1'b1;
      hold(1'b1, 10);
      send_header(25, 1);
      check(exp_q.size() == 0, "R8 works after enable", exp_q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule